// File: doc/BRIEF.md
# Memory-Card Slot Status Register Block

This block is a small set of memory-mapped words that sits next to a memory-card slot on a 32-bit register bus. Two of the words are fixed: an identification word and a decode word. A third word always reads zero. The status word carries two bits. One is a live copy of the slot's write-protect switch. The other is a sticky flag that records a card insertion.

The insertion flag drives an interrupt line. It stays set until software writes a one to its bit position in the status word. Both slot inputs are asynchronous. Each passes through a two-flop synchroniser before the block uses it.

Accesses are selected by a word index. A read returns its data combinationally in the same cycle as the access. A write takes effect at the clock edge that ends the access cycle.

Top module: `slot_status_regs`

## Requirements
- R1: After reset, the status word (index 2) reads 0 and `card_irq` is low.
- R2: Index 0 reads 0x41034003, index 1 reads 0x00000000, and index 3 reads 0x00000011.
- R3: Status bit 0 equals the level of `wp_in` after two clock edges of synchronisation. A level present before edge k is readable after edge k+1.
- R4: When `card_in` is high, status bit 3 and `card_irq` become 1 after three clock edges. A later fall of `card_in` leaves them set.
- R5: A write to index 2 whose data has bit 3 set clears status bit 3 and `card_irq` at that clock edge. Every other data bit in such a write has no effect.
- R6: If the synchronised card input is high at the edge of a clearing write, the set wins and bit 3 stays 1.
- R7: Writes to index 0, 1, 3 and to indices 4 and above change nothing.
- R8: Reads of indices 4 and above return 0. In the status word, every bit other than 0 and 3 reads 0.
- R9: `card_irq` always equals status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | IDX_W | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access, 0 otherwise |
| wp_in | input | 1 | Write-protect switch level, asynchronous |
| card_in | input | 1 | Card-insertion indication, asynchronous |
| card_irq | output | 1 | Insertion interrupt, level |

## Verification
The assertions assume the bus holds its signals stable for a whole cycle and changes them only away from the clock edge. They also assume that reset is asserted once at start-up and not again. The bench drives every input one time unit after a rising edge. It holds `card_in` high for at least one full cycle whenever it raises it, so that the synchroniser sees the pulse. Random stimulus mixes reads and writes to all sixteen indices with random data and random slot levels. A bench model of the two synchroniser stages predicts every value.

// File: rtl/slot_regs_pkg.sv
package slot_regs_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_WORDS  = 4;
  localparam int WP_BIT     = 0;
  localparam int CARD_BIT   = 3;
  localparam logic [DATA_W-1:0] ID_WORD     = 32'h4103_4003;
  localparam logic [DATA_W-1:0] DECODE_WORD = 32'h0000_0011;
  localparam logic [DATA_W-1:0] CLR_MASK    = DATA_W'(1) << CARD_BIT;

  typedef enum int {
    IDX_ID     = 0,
    IDX_PROG   = 1,
    IDX_STATUS = 2,
    IDX_DECODE = 3
  } word_idx_e;

  function automatic logic [DATA_W-1:0] pack_status(input logic wp, input logic card);
    logic [DATA_W-1:0] w;
    w = '0;
    w[WP_BIT]   = wp;
    w[CARD_BIT] = card;
    return w;
  endfunction

  function automatic logic clear_hit(input logic [DATA_W-1:0] wdata);
    return |(wdata & CLR_MASK);
  endfunction
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/slot_event_latch.sv
module slot_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/slot_read_mux.sv
module slot_read_mux
  import slot_regs_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (int'(idx_i))
        IDX_ID:     rdata_o = ID_WORD;
        IDX_PROG:   rdata_o = '0;
        IDX_STATUS: rdata_o = status_i;
        IDX_DECODE: rdata_o = DECODE_WORD;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/slot_status_regs.sv
module slot_status_regs
  import slot_regs_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wp_in,
  input  logic              card_in,
  output logic              card_irq
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] synced;
  logic              wp_sync;
  logic              card_sync;
  logic              clr_evt;
  logic              rd_evt;
  logic              card_flag;
  logic [DATA_W-1:0] status_word;

  assign raw_in    = {card_in, wp_in};
  assign wp_sync   = synced[0];
  assign card_sync = synced[1];

  slot_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (synced)
  );

  assign clr_evt = bus_en && bus_wr && (int'(bus_idx) == IDX_STATUS)
                   && clear_hit(bus_wdata);
  assign rd_evt  = bus_en && !bus_wr;

  slot_event_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (card_sync),
    .clr_i (clr_evt),
    .q_o   (card_flag)
  );

  assign status_word = pack_status(wp_sync, card_flag);
  assign card_irq    = card_flag;

  slot_read_mux #(.IDX_W(IDX_W)) u_rmux (
    .rd_i     (rd_evt),
    .idx_i    (bus_idx),
    .status_i (status_word),
    .rdata_o  (bus_rdata)
  );
endmodule

// File: rtl/slot_status_chk.sv
module slot_status_chk
  import slot_regs_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [IDX_W-1:0]  bus_idx,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              card_irq,
  input logic              card_sync,
  input logic              clr_evt
);
  // R4: a synchronised insertion raises the interrupt on the next edge
  assert_set_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    card_sync |=> card_irq);

  // R4 / R5: the interrupt only drops after a clearing write
  assert_fall_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_irq) |-> $past(clr_evt));

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !card_sync) |=> !card_irq);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && card_sync) |=> card_irq);

  assert_id_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && int'(bus_idx) == IDX_ID) |-> bus_rdata == ID_WORD);

  assert_out_range_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && int'(bus_idx) >= NUM_WORDS) |-> bus_rdata == '0);

  assert_status_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && int'(bus_idx) == IDX_STATUS) |-> bus_rdata[CARD_BIT] == card_irq);

  assert_status_spare_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && int'(bus_idx) == IDX_STATUS) |->
      (bus_rdata & ~pack_status(1'b1, 1'b1)) == '0);
endmodule

bind slot_status_regs slot_status_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_wr    (bus_wr),
  .bus_idx   (bus_idx),
  .bus_rdata (bus_rdata),
  .card_irq  (card_irq),
  .card_sync (card_sync),
  .clr_evt   (clr_evt)
);

// File: tb/slot_status_regs_test.sv
module slot_status_regs_test;
  localparam int CLK_P = 10;
  localparam int IDX_W = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0;
  logic        bus_wr = 0;
  logic [IDX_W-1:0] bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wp_in = 0;
  logic        card_in = 0;
  logic        card_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the synchroniser stages and the flag
  logic m_w1 = 0, m_w2 = 0, m_c1 = 0, m_c2 = 0, m_card = 0;

  always #(CLK_P/2) clk = ~clk;

  slot_status_regs #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wp_in(wp_in), .card_in(card_in), .card_irq(card_irq)
  );

  function automatic logic [31:0] expect_read(input int idx, input logic wp, input logic card);
    case (idx)
      0: return 32'h4103_4003;
      2: return (32'(card) << 3) | 32'(wp);
      3: return 32'h11;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic rd(input int idx, input string req, input logic [31:0] exp);
    bus_en = 1; bus_wr = 0; bus_idx = IDX_W'(idx);
    #1;
    check(req, bus_rdata, exp);
    bus_en = 0;
  endtask

  task automatic wr(input int idx, input logic [31:0] data);
    bus_en = 1; bus_wr = 1; bus_idx = IDX_W'(idx); bus_wdata = data;
    edges(1);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    edges(3);
    rst_n = 1;
    #1;
    check("R1 irq", 32'(card_irq), 0);
    rd(2, "R1 status", 0);

    rd(0, "R2 id", 32'h4103_4003);
    rd(1, "R2 prog", 0);
    rd(3, "R2 decode", 32'h11);
    rd(5, "R8 idx5", 0);
    rd(15, "R8 idx15", 0);

    // R3 synchroniser latency
    wp_in = 1;
    edges(1);
    rd(2, "R3 after one edge", 0);
    edges(1);
    rd(2, "R3 after two edges", 1);
    wp_in = 0;
    edges(2);
    rd(2, "R3 follows low", 0);

    // R4 set and hold
    card_in = 1;
    edges(2);
    check("R4 not yet", 32'(card_irq), 0);
    edges(1);
    check("R4 irq set", 32'(card_irq), 1);
    rd(2, "R4 status bit3", 32'h8);
    card_in = 0;
    edges(4);
    check("R4 sticky", 32'(card_irq), 1);

    // R5 other bits have no effect; bit3 clears
    wr(2, 32'hFFFF_FFF7);
    check("R5 no clear", 32'(card_irq), 1);
    wr(2, 32'h0000_0008);
    check("R5 cleared irq", 32'(card_irq), 0);
    rd(2, "R9 status after clear", 0);

    // R6 set wins
    card_in = 1;
    edges(3);
    wr(2, 32'h8);
    check("R6 set priority", 32'(card_irq), 1);
    card_in = 0;
    edges(3);
    wr(2, 32'h8);
    check("R6 later clear", 32'(card_irq), 0);

    // R7 ignored writes
    card_in = 1; edges(3); card_in = 0; edges(3);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    check("R7 irq kept", 32'(card_irq), 1);
    rd(2, "R7 status kept", 32'h8);
    rd(0, "R7 id kept", 32'h4103_4003);
    rd(3, "R7 decode kept", 32'h11);
    wr(2, 32'h8);
    edges(3);

    // random phase, model starts all zero
    for (int i = 0; i < 3000; i++) begin
      logic clr;
      int idx;
      wp_in   = 1'($urandom_range(0, 1));
      card_in = ($urandom_range(0, 9) == 0);
      idx     = int'($urandom_range(0, 15));
      bus_en  = 1'($urandom_range(0, 1));
      bus_wr  = 1'($urandom_range(0, 1));
      bus_idx = IDX_W'(idx);
      bus_wdata = $urandom();
      if ($urandom_range(0, 3) == 0) begin
        bus_wdata[3] = 1'b1;
        if (bus_wr) bus_idx = 2;
      end
      idx = int'(bus_idx);
      #1;
      if (bus_en && !bus_wr) check("R3/R4/R8 random read", bus_rdata, expect_read(idx, m_w2, m_card));
      check("R9 random irq", 32'(card_irq), 32'(m_card));
      clr = bus_en && bus_wr && idx == 2 && bus_wdata[3];
      @(posedge clk);
      m_card = m_c2 | (m_card & ~clr);
      m_w2 = m_w1; m_w1 = wp_in;
      m_c2 = m_c1; m_c1 = card_in;
      #1;
    end
    bus_en = 0;
    done = 1;
    summary();
  end
endmodule